// File: doc/BRIEF.md
# APM Command and Status Handshake Port

This block provides two byte-wide registers that firmware and the operating system use to pass requests to each other: a command byte and a status byte at two adjacent I/O offsets. Software writes the command byte to ask the platform for a power-management service. Software can read both bytes back at any time.

In the normal mode, every write to the command byte raises a one-clock system-management interrupt request toward the processor. The firmware handler then performs the service.

A second mode stands in for that handler in hardware. Two command codes directly control an SCI-enable flag that is exported to the power-management event logic. The code 0xF0 turns the flag off and 0xF1 turns it on. Each change also emits a one-clock set or clear pulse. Status writes are plain storage in both modes.

Top module: `apm_port`

## Requirements
- R1: After synchronous active-low reset, the command and status bytes read 0x00, the SCI-enable flag is 0, and the SMI, SCI-set and SCI-clear pulses are 0.
- R2: Only address bit 0 is decoded. Bit 0 = 0 selects the command byte and bit 0 = 1 selects the status byte. All higher address bits are ignored for both reads and writes.
- R3: Each register reads back the last byte written to it. A register holds its value while it is not written.
- R4: With emu_mode = 0, every command write drives smi_pulse high for exactly the clock cycle after the write edge, whatever the byte written.
- R5: With emu_mode = 0, command writes leave sci_set, sci_clr and sci_en unchanged, including writes of 0xF0 and 0xF1.
- R6: With emu_mode = 1, a command write of 0xF0 clears sci_en and pulses sci_clr for one cycle. A command write of 0xF1 sets sci_en and pulses sci_set for one cycle. No SMI is raised in this mode.
- R7: With emu_mode = 1, a command write of any other code only updates the command byte. It raises no pulse and leaves sci_en unchanged.
- R8: A status write never raises smi_pulse, sci_set or sci_clr, and never changes sci_en, in either mode.
- R9: Each pulse lasts one cycle per write. It falls in the cycle after the write when no further qualifying write follows. The SMI pulse never coincides with an SCI set or clear pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W (4) | Byte address; only bit 0 is decoded |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the addressed register (combinational) |
| emu_mode | input | 1 | 0: raise an SMI on command writes; 1: decode the SCI codes |
| smi_pulse | output | 1 | One-cycle SMI request |
| sci_set | output | 1 | One-cycle pulse when the SCI-enable flag is set |
| sci_clr | output | 1 | One-cycle pulse when the SCI-enable flag is cleared |
| sci_en | output | 1 | SCI-enable flag |

## Verification
The bench builds the block with ADDR_W = 4 and the default command codes 0xF0 and 0xF1. The wider address lets random upper address bits reach both registers, which shows that only bit 0 is decoded. Command values are weighted toward the two special codes and their near neighbours, and the mode is toggled freely. This covers the following cases:
- repeated sets and repeated clears,
- special codes written in SMI mode,
- special codes written to the status byte,
- back-to-back writes, where a pulse must stay high across cycles.

// File: rtl/apm_pkg.sv
// Package: shared constants and types for the APM handshake port.
// Assumes byte-wide registers and two register slots.
package apm_pkg;
    localparam int DATA_W = 8;
    localparam int NUM_REGS = 2;
    localparam logic [DATA_W-1:0] CODE_SCI_OFF = 8'hF0;
    localparam logic [DATA_W-1:0] CODE_SCI_ON = 8'hF1;

    typedef enum logic {
        SEL_CMD = 1'b0,
        SEL_STS = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/apm_addr_decode.sv
// Module: apm_addr_decode
// Turns the address and write strobe into per-register write enables.
// Assumes that only address bit 0 selects a register and that the
// upper bits are don't-care.
module apm_addr_decode #(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output apm_pkg::reg_sel_e sel,
    output logic              wr_cmd,
    output logic              wr_sts
);
    import apm_pkg::*;

    // Purpose: select a register from bit 0 and qualify the write strobe.
    always_comb begin
        sel    = reg_sel_e'(addr[0]);
        wr_cmd = wr_en && (sel == SEL_CMD);
        wr_sts = wr_en && (sel == SEL_STS);
    end
endmodule

// File: rtl/apm_byte_regs.sv
// Module: apm_byte_regs
// Holds the command and status bytes and drives the read mux.
// Assumes at most one write per cycle, and that the write enables
// are already decoded.
module apm_byte_regs (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_cmd,
    input  logic                      wr_sts,
    input  logic [apm_pkg::DATA_W-1:0] wr_data,
    input  apm_pkg::reg_sel_e          sel,
    output logic [apm_pkg::DATA_W-1:0] rd_data
);
    import apm_pkg::*;

    logic [NUM_REGS-1:0]             wr_vec;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

    // Purpose: gather the per-register write enables into one vector.
    always_comb begin
        wr_vec = '0;
        wr_vec[SEL_CMD] = wr_cmd;
        wr_vec[SEL_STS] = wr_sts;
    end

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        // Purpose: load one byte register on its own write enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[gi] <= '0;
            end else if (wr_vec[gi]) begin
                regs_q[gi] <= wr_data;
            end
        end
    end

    // Purpose: return the selected register.
    always_comb begin
        rd_data = regs_q[sel];
    end

    // R3: without a write, the stored bytes do not move.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vec == '0) |=> $stable(regs_q));

    // R3: a write to one slot leaves the other slot untouched.
    p_one_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd |=> $stable(regs_q[SEL_STS]));

    // At most one register is written per cycle.
    p_one_hot_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec));
endmodule

// File: rtl/apm_cmd_action.sv
// Module: apm_cmd_action
// Reacts to command writes. In SMI mode it raises a registered
// one-cycle SMI pulse. In emulated mode it decodes the two SCI codes
// into set/clear pulses and keeps the SCI-enable flag.
// Assumes that wr_cmd is high for the cycle of the write.
module apm_cmd_action #(
    parameter logic [apm_pkg::DATA_W-1:0] CODE_OFF = apm_pkg::CODE_SCI_OFF,
    parameter logic [apm_pkg::DATA_W-1:0] CODE_ON  = apm_pkg::CODE_SCI_ON
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_cmd,
    input  logic [apm_pkg::DATA_W-1:0] wr_data,
    input  logic                       emu_mode,
    output logic                       smi_pulse,
    output logic                       sci_set,
    output logic                       sci_clr,
    output logic                       sci_en
);
    logic smi_d;
    logic set_d;
    logic clr_d;

    // Purpose: decide what the current command write requests.
    always_comb begin
        smi_d = wr_cmd && !emu_mode;
        set_d = wr_cmd && emu_mode && (wr_data == CODE_ON);
        clr_d = wr_cmd && emu_mode && (wr_data == CODE_OFF);
    end

    // Purpose: register the one-cycle request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smi_pulse <= 1'b0;
            sci_set   <= 1'b0;
            sci_clr   <= 1'b0;
        end else begin
            smi_pulse <= smi_d;
            sci_set   <= set_d;
            sci_clr   <= clr_d;
        end
    end

    // Purpose: keep the SCI-enable flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sci_en <= 1'b0;
        end else if (set_d) begin
            sci_en <= 1'b1;
        end else if (clr_d) begin
            sci_en <= 1'b0;
        end
    end

    // R6: the flag only rises together with a set pulse.
    p_rise_needs_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sci_en) |-> sci_set);

    // R6: the flag only falls together with a clear pulse.
    p_fall_needs_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sci_en) |-> sci_clr);

    // R9: the SMI pulse never overlaps an SCI pulse.
    p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(smi_pulse && (sci_set || sci_clr)));

    // R6: set and clear are never requested together.
    p_set_clr_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sci_set && sci_clr));

    // R5: in SMI mode, a command write leaves the flag as it was.
    p_smi_mode_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !emu_mode) |=> $stable(sci_en));
endmodule

// File: rtl/apm_port.sv
// Module: apm_port (top)
// APM command/status handshake port with an SMI trigger and an
// optional hardware stand-in for the firmware SCI enable/disable
// handler. Assumes a synchronous active-low reset and at most one
// write per cycle. Reads are combinational.
module apm_port #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic              emu_mode,
    output logic              smi_pulse,
    output logic              sci_set,
    output logic              sci_clr,
    output logic              sci_en
);
    import apm_pkg::*;

    reg_sel_e sel;
    logic     wr_cmd;
    logic     wr_sts;

    apm_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (addr),
        .wr_en  (wr_en),
        .sel    (sel),
        .wr_cmd (wr_cmd),
        .wr_sts (wr_sts)
    );

    apm_byte_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_cmd  (wr_cmd),
        .wr_sts  (wr_sts),
        .wr_data (wr_data),
        .sel     (sel),
        .rd_data (rd_data)
    );

    apm_cmd_action u_act (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cmd    (wr_cmd),
        .wr_data   (wr_data),
        .emu_mode  (emu_mode),
        .smi_pulse (smi_pulse),
        .sci_set   (sci_set),
        .sci_clr   (sci_clr),
        .sci_en    (sci_en)
    );

    // R4: every command write in SMI mode is followed by an SMI pulse.
    p_cmd_smi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr[0] && !emu_mode) |=> smi_pulse);

    // R4: an SMI pulse always traces back to such a write.
    p_smi_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        smi_pulse |-> $past(wr_en && !addr[0] && !emu_mode));

    // R8: status writes raise nothing and leave the flag alone.
    p_sts_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[0]) |=> (!smi_pulse && !sci_set && !sci_clr && $stable(sci_en)));

    // R9: with no write, every pulse falls in the next cycle.
    p_pulse_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!smi_pulse && !sci_set && !sci_clr));
endmodule

// File: tb/sim_apm_port.sv
module sim_apm_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       emu_mode = 1'b0;
    logic       smi_pulse;
    logic       sci_set;
    logic       sci_clr;
    logic       sci_en;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] m_cmd = '0;
    logic [7:0] m_sts = '0;
    logic       m_sci = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    apm_port #(.ADDR_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .emu_mode(emu_mode),
        .smi_pulse(smi_pulse), .sci_set(sci_set), .sci_clr(sci_clr),
        .sci_en(sci_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%02h expected=0x%02h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit f_smi(input logic [3:0] a, input bit emu);
        return !a[0] && !emu;
    endfunction

    function automatic bit f_set(input logic [3:0] a, input logic [7:0] d, input bit emu);
        return !a[0] && emu && (d == 8'hF1);
    endfunction

    function automatic bit f_clr(input logic [3:0] a, input logic [7:0] d, input bit emu);
        return !a[0] && emu && (d == 8'hF0);
    endfunction

    // One write, then a check of the pulses and the flag at the next negedge.
    task automatic wr(input logic [3:0] a, input logic [7:0] d, input bit emu, input string req);
        bit es;
        bit et;
        bit ec;
        es = f_smi(a, emu);
        et = f_set(a, d, emu);
        ec = f_clr(a, d, emu);
        addr = a;
        wr_data = d;
        emu_mode = emu;
        wr_en = 1'b1;
        if (a[0]) m_sts = d;
        else m_cmd = d;
        if (et) m_sci = 1'b1;
        if (ec) m_sci = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        check({req, " smi"}, {7'd0, smi_pulse}, {7'd0, es});
        check({req, " set"}, {7'd0, sci_set}, {7'd0, et});
        check({req, " clr"}, {7'd0, sci_clr}, {7'd0, ec});
        check({req, " flag"}, {7'd0, sci_en}, {7'd0, m_sci});
    endtask

    // One idle cycle: all pulses must be low again.
    task automatic idle_chk(input string req);
        @(negedge clk);
        check({req, " smi idle"}, {7'd0, smi_pulse}, 8'd0);
        check({req, " set idle"}, {7'd0, sci_set}, 8'd0);
        check({req, " clr idle"}, {7'd0, sci_clr}, 8'd0);
    endtask

    task automatic rd_chk(input logic [3:0] a, input string req);
        addr = a;
        #1;
        check(req, rd_data, a[0] ? m_sts : m_cmd);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 smi", {7'd0, smi_pulse}, 8'd0);
        check("R1 flag", {7'd0, sci_en}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk(4'h0, "R1 cmd");
        rd_chk(4'h1, "R1 sts");
        check("R1 set", {7'd0, sci_set}, 8'd0);
        check("R1 clr", {7'd0, sci_clr}, 8'd0);

        // R4 and R5: special codes in SMI mode raise an SMI only
        wr(4'h0, 8'hF1, 1'b0, "R5 F1 smi-mode");
        wr(4'h0, 8'hF0, 1'b0, "R4 F0 smi-mode");
        idle_chk("R9");
        // R6: set, set again, then clear
        wr(4'h2, 8'hF1, 1'b1, "R6 set");
        idle_chk("R9");
        wr(4'h0, 8'hF1, 1'b1, "R6 set again");
        wr(4'hE, 8'hF0, 1'b1, "R6 clear");
        // R7: a neighbouring code has no effect
        wr(4'h0, 8'hF1, 1'b1, "R6 set");
        wr(4'h0, 8'hF2, 1'b1, "R7 other code");
        rd_chk(4'h0, "R3 cmd readback");
        // R8: special codes written to status do nothing
        wr(4'h1, 8'hF0, 1'b1, "R8 sts F0");
        wr(4'hF, 8'hF0, 1'b0, "R8 sts F0 smi-mode");
        rd_chk(4'h3, "R2 upper bits sts");
        rd_chk(4'h6, "R2 upper bits cmd");
        // R9: back-to-back command writes keep the SMI pulse high
        wr(4'h0, 8'h00, 1'b0, "R9 b2b 1");
        wr(4'h0, 8'h55, 1'b0, "R9 b2b 2");
        idle_chk("R9");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [3:0] a;
            logic [7:0] d;
            bit emu;
            int pick;
            a = 4'($urandom);
            pick = int'($urandom % 8);
            case (pick)
                0, 1: d = 8'hF0;
                2, 3: d = 8'hF1;
                4: d = 8'hF0 + 8'($urandom % 4) - 8'd1;
                default: d = 8'($urandom);
            endcase
            emu = 1'($urandom);
            if (a[0]) wr(a, d, emu, "R8 rnd sts");
            else if (emu) wr(a, d, emu, "R6 R7 rnd cmd");
            else wr(a, d, emu, "R4 R5 rnd cmd");
            if (($urandom % 3) == 0) idle_chk("R9 rnd");
            rd_chk(4'($urandom), "R2 R3 rnd read");
        end

        // R1: reset again clears everything
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_cmd = '0;
        m_sts = '0;
        m_sci = 1'b0;
        rd_chk(4'h0, "R1 cmd after reset");
        rd_chk(4'h1, "R1 sts after reset");
        check("R1 flag after reset", {7'd0, sci_en}, 8'd0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule